// File: doc/BRIEF.md
# Non-Revertive Reference Failover Controller

This block is a synchronous control state machine that picks which of two reference clocks drives a downstream PLL. It does not touch the clocks. It produces a one-bit select level for an external clock multiplexer, plus a copy of that level as an acknowledge. In manual mode the select follows a manual-select input. In automatic mode the block arms once the PLL reports lock. A later loss of lock makes it swap to the other reference exactly once. It makes no further swap until it is put back through manual mode.

All three control inputs are treated as asynchronous: manual select, automatic enable and loss-of-lock. Each passes through a synchronizer chain of `SYNC_STAGES` flops. The loss-of-lock input is then edge-detected, so only a rising loss-of-lock counts as a fault.

Four states are used:
- `FO_MANUAL`: the select tracks the manual input.
- `FO_WAIT_LOCK`: automatic mode is requested but loss-of-lock is still high. The select still tracks the manual input and no swap can occur.
- `FO_ARMED`: the select is frozen.
- `FO_SPENT`: one swap has been made and the select is frozen again.

The transitions are:
- `FO_MANUAL` goes to `FO_ARMED` when enable is high and lock is present.
- `FO_MANUAL` goes to `FO_WAIT_LOCK` when enable is high and lock is absent.
- `FO_WAIT_LOCK` goes to `FO_ARMED` on the first cycle in which loss-of-lock is low.
- `FO_ARMED` goes to `FO_SPENT` on a loss-of-lock rise, and the select inverts.
- Any state goes to `FO_MANUAL` when enable goes low.

A one-cycle switch pulse and two status levels, armed and spent, are provided for monitoring.

Top module: `refsel_failover_ctrl`

## Requirements
- R1: During and right after reset the block is in manual mode with ref_sel_o=0, ref_ack_o=0, armed_o=0, spent_o=0 and switch_pulse_o=0.
- R2: While auto_en_i is low, ref_sel_o follows man_sel_i after a latency of SYNC_STAGES+1 clock edges. Value 0 selects reference 0 and value 1 selects reference 1.
- R3: When auto_en_i is high and lol_i is low, armed_o (1 = armed) rises. At the moment of arming, ref_sel_o holds the manual selection then in effect. armed_o and spent_o are never high together.
- R4: While armed, a rising lol_i inverts ref_sel_o. At the same time it sets spent_o to 1, clears armed_o, and raises switch_pulse_o for exactly one cycle.
- R5: After the swap, further loss-of-lock activity causes no further change of ref_sel_o and no switch pulse.
- R6: While armed or spent, changes of man_sel_i have no effect on ref_sel_o.
- R7: Driving auto_en_i low leaves armed or spent and returns to manual mode, where ref_sel_o again follows man_sel_i. Raising auto_en_i again with lol_i low re-arms the block.
- R8: ref_ack_o always equals ref_sel_o.
- R9: A loss-of-lock pulse one clock period wide while armed is enough to trigger the swap.
- R10: If auto_en_i rises while lol_i is high, the block stays unarmed and makes no swap, and ref_sel_o keeps following man_sel_i. It arms on the first synchronized cycle in which lol_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; its period must not exceed the shortest loss-of-lock pulse |
| rst_n | input | 1 | Active-low asynchronous reset |
| man_sel_i | input | 1 | Manual reference choice (asynchronous) |
| auto_en_i | input | 1 | Automatic-mode enable (asynchronous) |
| lol_i | input | 1 | PLL loss-of-lock level (asynchronous) |
| ref_sel_o | output | 1 | Active reference: 0 selects reference 0, 1 selects reference 1 |
| ref_ack_o | output | 1 | Acknowledge copy of the active reference |
| switch_pulse_o | output | 1 | One-cycle pulse on an automatic swap |
| armed_o | output | 1 | High while automatic mode is armed |
| spent_o | output | 1 | High after the one swap of the current arming |

## Verification
The bench targets four failure modes:
- A second fault while spent. A design that is not truly one-shot would swap back and forth on every loss-of-lock edge.
- A manual-select change while armed or spent. A design that let the manual input leak through would move the select behind the PLL's back.
- An automatic-enable rise during loss-of-lock. A design that armed on the enable alone would swap at once, or arm onto a reference that was never locked.
- A single-period loss-of-lock pulse and a re-arm from the spent state. These catch a level-only or mis-timed edge detector, and a design that keeps or loses the spent condition across manual mode.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        FO_MANUAL    = 2'd0,
        FO_WAIT_LOCK = 2'd1,
        FO_ARMED     = 2'd2,
        FO_SPENT     = 2'd3
    } fo_state_t;

    // Bit positions of the synchronized control bus
    localparam int unsigned CTL_MAN  = 0;
    localparam int unsigned CTL_AUTO = 1;
    localparam int unsigned CTL_LOL  = 2;
    localparam int unsigned CTL_W    = 3;

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/refsel_rise.sv
module refsel_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;

endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic man_s,
    input  logic auto_s,
    input  logic lol_s,
    input  logic lol_rise,
    output logic ref_sel,
    output logic switch_pulse,
    output logic armed,
    output logic spent
);

    fo_state_t state_q, state_d;
    logic      ref_q, ref_d;
    logic      pulse_q, pulse_d;

    // Next state and next reference
    always_comb begin
        state_d = state_q;
        ref_d   = ref_q;
        pulse_d = 1'b0;
        unique case (state_q)
            FO_MANUAL: begin
                ref_d = man_s;
                if (auto_s) state_d = lol_s ? FO_WAIT_LOCK : FO_ARMED;
            end
            FO_WAIT_LOCK: begin
                ref_d = man_s;
                if (!auto_s)     state_d = FO_MANUAL;
                else if (!lol_s) state_d = FO_ARMED;
            end
            FO_ARMED: begin
                if (!auto_s) begin
                    state_d = FO_MANUAL;
                    ref_d   = man_s;
                end else if (lol_rise) begin
                    state_d = FO_SPENT;
                    ref_d   = ~ref_q;
                    pulse_d = 1'b1;
                end
            end
            FO_SPENT: begin
                if (!auto_s) begin
                    state_d = FO_MANUAL;
                    ref_d   = man_s;
                end
            end
            default: begin
                state_d = FO_MANUAL;
                ref_d   = man_s;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FO_MANUAL;
            ref_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ref_q   <= ref_d;
            pulse_q <= pulse_d;
        end
    end

    // Outputs
    always_comb begin
        ref_sel      = ref_q;
        switch_pulse = pulse_q;
        armed        = (state_q == FO_ARMED);
        spent        = (state_q == FO_SPENT);
    end

endmodule

// File: rtl/refsel_failover_ctrl.sv
module refsel_failover_ctrl
    import refsel_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic man_sel_i,
    input  logic auto_en_i,
    input  logic lol_i,
    output logic ref_sel_o,
    output logic ref_ack_o,
    output logic switch_pulse_o,
    output logic armed_o,
    output logic spent_o
);

    logic [CTL_W-1:0] ctl_raw, ctl_s;
    logic             lol_rise;
    logic             ref_sel;

    always_comb begin
        ctl_raw           = '0;
        ctl_raw[CTL_MAN]  = man_sel_i;
        ctl_raw[CTL_AUTO] = auto_en_i;
        ctl_raw[CTL_LOL]  = lol_i;
    end

    refsel_sync #(
        .WIDTH  (CTL_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ctl_raw),
        .q_sync  (ctl_s)
    );

    refsel_rise lol_edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ctl_s[CTL_LOL]),
        .rise  (lol_rise)
    );

    refsel_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .man_s        (ctl_s[CTL_MAN]),
        .auto_s       (ctl_s[CTL_AUTO]),
        .lol_s        (ctl_s[CTL_LOL]),
        .lol_rise     (lol_rise),
        .ref_sel      (ref_sel),
        .switch_pulse (switch_pulse_o),
        .armed        (armed_o),
        .spent        (spent_o)
    );

    assign ref_sel_o = ref_sel;
    assign ref_ack_o = ref_sel;

endmodule

// File: rtl/refsel_failover_chk.sv
module refsel_failover_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_sel_o,
    input logic switch_pulse_o,
    input logic armed_o,
    input logic spent_o
);

    assert_armed_spent_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({armed_o, spent_o}));

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse_o |=> !switch_pulse_o);

    assert_pulse_flips_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse_o |-> (spent_o && (ref_sel_o != $past(ref_sel_o))));

    assert_pulse_only_from_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse_o |-> $past(armed_o));

    assert_no_direct_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spent_o) && !spent_o) |-> !armed_o);

    assert_spent_holds_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spent_o && $past(spent_o)) |-> $stable(ref_sel_o));

    assert_armed_holds_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && $past(armed_o)) |-> $stable(ref_sel_o));

endmodule

bind refsel_failover_ctrl refsel_failover_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ref_sel_o      (ref_sel_o),
    .switch_pulse_o (switch_pulse_o),
    .armed_o        (armed_o),
    .spent_o        (spent_o)
);

// File: tb/refsel_failover_ctrl_tb_top.sv
module refsel_failover_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic       man;
        logic       auto_en;
        logic       lol;
        logic       exp_ref;
        logic       exp_armed;
        logic       exp_spent;
        logic [1:0] exp_pulses;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},  // 0  R2 manual ref0
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},  // 1  R2 manual ref1
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},  // 2  R2 manual ref0
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0},  // 3  R3 arm
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0},  // 4  R6 manual ignored armed
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1},  // 5  R4 failover
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0},  // 6  R6 manual ignored spent
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0},  // 7  R5 no second swap
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},  // 8  R7 back to manual
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},  // 9  R10 wait
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},  // 10 R10 wait follows man
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},  // 11 R10 arms when lock
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1},  // 12 R4 failover to ref0
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},  // 13 R7 manual
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}   // 14 R7 rearm
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic man_sel_i = 1'b0;
    logic auto_en_i = 1'b0;
    logic lol_i = 1'b0;
    logic ref_sel_o, ref_ack_o, switch_pulse_o, armed_o, spent_o;

    int errors = 0;
    int checks = 0;
    int pulse_total = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refsel_failover_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .man_sel_i      (man_sel_i),
        .auto_en_i      (auto_en_i),
        .lol_i          (lol_i),
        .ref_sel_o      (ref_sel_o),
        .ref_ack_o      (ref_ack_o),
        .switch_pulse_o (switch_pulse_o),
        .armed_o        (armed_o),
        .spent_o        (spent_o)
    );

    always @(negedge clk) if (switch_pulse_o) pulse_total++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0, 1, 2:   return "R2";
            3:         return "R3";
            4, 6:      return "R6";
            5, 12:     return "R4";
            7:         return "R5";
            8, 13, 14: return "R7";
            default:   return "R10";
        endcase
    endfunction

    initial begin
        int p0;
        // R1: reset state, manual input high must not show before sync latency
        man_sel_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "ref in reset", int'(ref_sel_o), 0);
        check("R1", "armed in reset", int'(armed_o), 0);
        check("R1", "spent in reset", int'(spent_o), 0);
        check("R1", "pulse in reset", int'(switch_pulse_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ref right after reset", int'(ref_sel_o), 0);
        check("R8", "ack right after reset", int'(ref_ack_o), 0);
        repeat (SETTLE) @(negedge clk);
        check("R2", "ref follows man after reset", int'(ref_sel_o), 1);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            man_sel_i = VECS[i].man;
            auto_en_i = VECS[i].auto_en;
            lol_i     = VECS[i].lol;
            p0 = pulse_total;
            repeat (SETTLE) @(negedge clk);
            check(row_tag(i), $sformatf("ref row %0d", i), int'(ref_sel_o), int'(VECS[i].exp_ref));
            check("R8", $sformatf("ack row %0d", i), int'(ref_ack_o), int'(VECS[i].exp_ref));
            check(row_tag(i), $sformatf("armed row %0d", i), int'(armed_o), int'(VECS[i].exp_armed));
            check(row_tag(i), $sformatf("spent row %0d", i), int'(spent_o), int'(VECS[i].exp_spent));
            check(row_tag(i), $sformatf("pulses row %0d", i), pulse_total - p0, int'(VECS[i].exp_pulses));
        end

        // R9: single-period loss-of-lock pulse while armed (armed on ref1 now)
        p0 = pulse_total;
        lol_i = 1'b1;
        @(negedge clk);
        lol_i = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R9", "ref after short pulse", int'(ref_sel_o), 0);
        check("R9", "spent after short pulse", int'(spent_o), 1);
        check("R9", "pulse count short pulse", pulse_total - p0, 1);

        // R5: repeated short pulses while spent do nothing
        p0 = pulse_total;
        for (int k = 0; k < 3; k++) begin
            lol_i = 1'b1;
            @(negedge clk);
            lol_i = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (SETTLE) @(negedge clk);
        check("R5", "ref after pulses in spent", int'(ref_sel_o), 0);
        check("R5", "no pulses in spent", pulse_total - p0, 0);

        // R7: re-arm from spent, then manual ref0 choice
        man_sel_i = 1'b0;
        auto_en_i = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R7", "spent cleared", int'(spent_o), 0);
        auto_en_i = 1'b1;
        repeat (SETTLE) @(negedge clk);
        check("R7", "rearmed", int'(armed_o), 1);
        check("R7", "ref at rearm", int'(ref_sel_o), 0);

        // R1: asynchronous reset mid-operation
        rst_n = 1'b0;
        #1;
        check("R1", "armed cleared by reset", int'(armed_o), 0);
        check("R1", "ref cleared by reset", int'(ref_sel_o), 0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule